// File: doc/BRIEF.md
# Dual-Bank Flash Access Arbiter

This block sits between a host and a flash array that is split into two banks of unequal size. A strap input picks one of two ways to divide the address space into a small bank (one quarter) and a big bank (three quarters). Each host access is mapped to a bank. The block then decides whether the array serves the access, whether a status word is returned instead, or whether the access is refused with an error. One registered response follows each access.

Embedded program and erase operations are started with a one-cycle start pulse and ended with a per-bank done pulse. One bank can be busy while host accesses to the other bank run at full speed. A sector erase can be suspended. While it is suspended, the rest of that bank may be read, and other sectors in it may be programmed. Two mode inputs model the special states of the device. The first turns concurrency off completely. The second always sends the big bank to the array and the small bank to status.

Top module: `dual_bank_arbiter`

Each bank runs its own state machine. The states are `B_IDLE`, `B_PROG` (program running), `B_ERASE` (sector or whole-array erase running), `B_SUSP` (sector erase suspended) and `B_SPROG` (program running inside a suspended erase). The transitions are:
- `B_IDLE` to `B_PROG` on an admitted program start.
- `B_IDLE` to `B_ERASE` on an admitted sector or whole-array erase.
- `B_PROG` to `B_IDLE` on done.
- `B_ERASE` to `B_IDLE` on done.
- `B_ERASE` to `B_SUSP` on suspend, for a sector erase only.
- `B_SUSP` to `B_ERASE` on resume.
- `B_SUSP` to `B_SPROG` on an admitted program start.
- `B_SPROG` to `B_SUSP` on done.

The op-kind encoding is 0 = program, 1 = sector erase, 2 = whole-array erase and 3 = invalid. A sector is `host_addr[19:16]`, and the bank is decoded from `host_addr[19:18]`.

## Requirements
- R1: With `part_opt`=0, address bits [19:18]=00 select bank 0 and 01, 10, 11 select bank 1. `acc_bank` reports the bank of the served access.
- R2: With `part_opt`=1, address bits [19:18]=00, 01, 10 select bank 0 and only 11 selects bank 1.
- R3: An access to a bank in `B_IDLE` gives `arr_en`=1 one cycle after `host_req`. `arr_we` copies `host_we`. This holds even while the other bank is busy.
- R4: An access to a bank in `B_PROG`, `B_ERASE` or `B_SPROG` gives `resp_status`=1 and `arr_en`=0. The bank's `bank_busy` bit stays high until its `bank_done` pulses, unless it is suspended.
- R5: A start (op kind 0 or 1) to a bank that is busy, and any start with op kind 3, produce an `op_err` pulse one cycle long. The running operation keeps its state.
- R6: `susp_req` moves a bank from `B_ERASE` (sector erase) to `B_SUSP`, which gives `bank_busy`=0 and `bank_susp`=1. `resume_req` returns it to `B_ERASE`.
- R7: An access to the sector whose erase is suspended gives `resp_err`=1 and `arr_en`=0. Other sectors of that bank give `arr_en`=1.
- R8: A program start to a suspended bank is admitted to `B_SPROG` (busy and suspended both high) when it targets another sector, and done returns the bank to `B_SUSP`. A program start to the suspended sector raises `op_err`.
- R9: With `mode_noconc`=1, every access returns status while any bank is busy. Accesses go to the array when both banks are idle.
- R10: With `mode_split`=1, accesses to the big bank go to the array and accesses to the small bank return status. Bank 0 is small under option 0 and big under option 1.
- R11: A whole-array erase is admitted only when both banks are in `B_IDLE` and makes both banks busy. Otherwise `op_err` pulses. Suspend has no effect on it. Each bank's done releases that bank.
- R12: After reset, `bank_busy`, `bank_susp`, `arr_en`, `resp_status`, `resp_err` and `op_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| part_opt | input | 1 | Strap that selects the partition option |
| mode_noconc | input | 1 | Special mode that turns concurrency off |
| mode_split | input | 1 | Special mode: big bank reads the array, small bank returns status |
| host_req | input | 1 | Host access strobe |
| host_we | input | 1 | Host access is a write |
| host_addr | input | ADDR_W | Host address, also used as the target of a start |
| op_start | input | 1 | Start of an embedded operation |
| op_kind | input | 2 | Kind of operation: 0 program, 1 sector erase, 2 whole-array erase |
| susp_req | input | 1 | Suspend sector erase |
| resume_req | input | 1 | Resume suspended erase |
| bank_done | input | 2 | Per-bank completion pulse |
| arr_en | output | 1 | Access is served by the array |
| arr_we | output | 1 | Array access is a write |
| arr_addr | output | ADDR_W | Address of the array access |
| acc_bank | output | 1 | Decoded bank of the last access |
| resp_status | output | 1 | Status word is returned |
| resp_err | output | 1 | Access refused (suspended sector) |
| op_err | output | 1 | Start request rejected |
| bank_busy | output | 2 | Per-bank embedded operation running |
| bank_susp | output | 2 | Per-bank erase suspended |

## Verification
Access responses (`arr_en`, `resp_status`, `resp_err`, `acc_bank`, `arr_we`) and `op_err` are registered, so they are due one clock after the cycle that presents the request. Bank state (`bank_busy`, `bank_susp`) also changes on that same edge after a start, done, suspend or resume. The bench drives every stimulus on a falling edge for exactly one cycle. It samples on the following falling edge, which is one rising edge later, and that is the edge on which every result is due. Single-cycle pulse behaviour of `op_err` is confirmed by sampling again one further falling edge later.

// File: rtl/dba_pkg.sv
package dba_pkg;

    typedef enum logic [2:0] {
        B_IDLE  = 3'd0,
        B_PROG  = 3'd1,
        B_ERASE = 3'd2,
        B_SUSP  = 3'd3,
        B_SPROG = 3'd4
    } bank_st_e;

    typedef enum logic [1:0] {
        OP_PROG   = 2'd0,
        OP_SERASE = 2'd1,
        OP_CERASE = 2'd2,
        OP_BAD    = 2'd3
    } op_kind_e;

    typedef enum logic [1:0] {
        RSP_NONE   = 2'd0,
        RSP_ARRAY  = 2'd1,
        RSP_STATUS = 2'd2,
        RSP_ERROR  = 2'd3
    } resp_e;

    function automatic logic st_busy(bank_st_e s);
        return (s == B_PROG) || (s == B_ERASE) || (s == B_SPROG);
    endfunction

endpackage

// File: rtl/dba_bank_decode.sv
module dba_bank_decode (
    input  logic       part_opt,
    input  logic [1:0] addr_hi,
    output logic       bank,
    output logic       is_big
);
    always_comb begin
        if (part_opt == 1'b0) begin
            bank   = (addr_hi != 2'b00);
            is_big = bank;
        end else begin
            bank   = (addr_hi == 2'b11);
            is_big = ~bank;
        end
    end
endmodule

// File: rtl/dba_bank_fsm.sv
module dba_bank_fsm
    import dba_pkg::*;
#(
    parameter int SECT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_prog,
    input  logic              start_erase,
    input  logic              start_chip,
    input  logic [SECT_W-1:0] start_sect,
    input  logic              suspend,
    input  logic              resume,
    input  logic              done,
    output bank_st_e          state,
    output logic [SECT_W-1:0] susp_sect,
    output logic              busy,
    output logic              susp
);
    bank_st_e st_q, st_d;
    logic     chip_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= B_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chip_q    <= 1'b0;
            susp_sect <= '0;
        end else begin
            if (st_q == B_IDLE && start_chip)        chip_q <= 1'b1;
            else if (st_q == B_IDLE && start_erase)  chip_q <= 1'b0;
            if (st_q == B_IDLE && start_erase && !start_chip) susp_sect <= start_sect;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            B_IDLE: begin
                if (start_chip || start_erase) st_d = B_ERASE;
                else if (start_prog)           st_d = B_PROG;
            end
            B_PROG: begin
                if (done) st_d = B_IDLE;
            end
            B_ERASE: begin
                if (done)                  st_d = B_IDLE;
                else if (suspend && !chip_q) st_d = B_SUSP;
            end
            B_SUSP: begin
                if (resume)          st_d = B_ERASE;
                else if (start_prog) st_d = B_SPROG;
            end
            B_SPROG: begin
                if (done) st_d = B_SUSP;
            end
            default: st_d = B_IDLE;
        endcase
    end

    always_comb begin
        state = st_q;
        busy  = st_busy(st_q);
        susp  = (st_q == B_SUSP) || (st_q == B_SPROG);
    end
endmodule

// File: rtl/dba_op_admit.sv
module dba_op_admit
    import dba_pkg::*;
#(
    parameter int SECT_W = 4
) (
    input  logic              op_start,
    input  logic [1:0]        op_kind,
    input  logic              tgt_bank,
    input  logic [SECT_W-1:0] tgt_sect,
    input  bank_st_e          st0,
    input  bank_st_e          st1,
    input  logic [SECT_W-1:0] ss0,
    input  logic [SECT_W-1:0] ss1,
    output logic [1:0]        start_prog,
    output logic [1:0]        start_erase,
    output logic              start_chip,
    output logic              reject
);
    bank_st_e          tst;
    logic [SECT_W-1:0] tss;

    always_comb begin
        tst         = tgt_bank ? st1 : st0;
        tss         = tgt_bank ? ss1 : ss0;
        start_prog  = 2'b00;
        start_erase = 2'b00;
        start_chip  = 1'b0;
        reject      = 1'b0;
        if (op_start) begin
            unique case (op_kind_e'(op_kind))
                OP_PROG: begin
                    if (tst == B_IDLE || (tst == B_SUSP && tgt_sect != tss))
                        start_prog[tgt_bank] = 1'b1;
                    else
                        reject = 1'b1;
                end
                OP_SERASE: begin
                    if (tst == B_IDLE) start_erase[tgt_bank] = 1'b1;
                    else               reject = 1'b1;
                end
                OP_CERASE: begin
                    if (st0 == B_IDLE && st1 == B_IDLE) start_chip = 1'b1;
                    else                                reject = 1'b1;
                end
                default: reject = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/dba_access_ctrl.sv
module dba_access_ctrl
    import dba_pkg::*;
#(
    parameter int SECT_W = 4
) (
    input  logic              req,
    input  logic              bank,
    input  logic              is_big,
    input  logic [SECT_W-1:0] sect,
    input  bank_st_e          st0,
    input  bank_st_e          st1,
    input  logic [SECT_W-1:0] ss0,
    input  logic [SECT_W-1:0] ss1,
    input  logic              mode_noconc,
    input  logic              mode_split,
    output resp_e             resp
);
    bank_st_e          tst;
    logic [SECT_W-1:0] tss;
    logic              any_busy;

    always_comb begin
        tst      = bank ? st1 : st0;
        tss      = bank ? ss1 : ss0;
        any_busy = st_busy(st0) || st_busy(st1);
        resp     = RSP_NONE;
        if (req) begin
            if (mode_noconc && any_busy) begin
                resp = RSP_STATUS;
            end else if (mode_split) begin
                resp = is_big ? RSP_ARRAY : RSP_STATUS;
            end else begin
                unique case (tst)
                    B_IDLE:  resp = RSP_ARRAY;
                    B_SUSP:  resp = (sect == tss) ? RSP_ERROR : RSP_ARRAY;
                    default: resp = RSP_STATUS;
                endcase
            end
        end
    end
endmodule

// File: rtl/dual_bank_arbiter.sv
module dual_bank_arbiter
    import dba_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int SECT_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              part_opt,
    input  logic              mode_noconc,
    input  logic              mode_split,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              op_start,
    input  logic [1:0]        op_kind,
    input  logic              susp_req,
    input  logic              resume_req,
    input  logic [1:0]        bank_done,
    output logic              arr_en,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              acc_bank,
    output logic              resp_status,
    output logic              resp_err,
    output logic              op_err,
    output logic [1:0]        bank_busy,
    output logic [1:0]        bank_susp
);
    localparam int SECT_W = ADDR_W - SECT_LSB;
    localparam int NB     = 2;

    logic              dec_bank, dec_big;
    logic [SECT_W-1:0] sect;
    bank_st_e          st     [NB];
    logic [SECT_W-1:0] ss     [NB];
    logic [1:0]        s_prog, s_erase;
    logic              s_chip, reject;
    resp_e             resp;

    assign sect = host_addr[ADDR_W-1:SECT_LSB];

    dba_bank_decode dec_i (
        .part_opt (part_opt),
        .addr_hi  (host_addr[ADDR_W-1 -: 2]),
        .bank     (dec_bank),
        .is_big   (dec_big)
    );

    dba_op_admit #(.SECT_W(SECT_W)) admit_i (
        .op_start    (op_start),
        .op_kind     (op_kind),
        .tgt_bank    (dec_bank),
        .tgt_sect    (sect),
        .st0         (st[0]),
        .st1         (st[1]),
        .ss0         (ss[0]),
        .ss1         (ss[1]),
        .start_prog  (s_prog),
        .start_erase (s_erase),
        .start_chip  (s_chip),
        .reject      (reject)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        dba_bank_fsm #(.SECT_W(SECT_W)) fsm_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .start_prog  (s_prog[b]),
            .start_erase (s_erase[b]),
            .start_chip  (s_chip),
            .start_sect  (sect),
            .suspend     (susp_req),
            .resume      (resume_req),
            .done        (bank_done[b]),
            .state       (st[b]),
            .susp_sect   (ss[b]),
            .busy        (bank_busy[b]),
            .susp        (bank_susp[b])
        );
    end

    dba_access_ctrl #(.SECT_W(SECT_W)) acc_i (
        .req         (host_req),
        .bank        (dec_bank),
        .is_big      (dec_big),
        .sect        (sect),
        .st0         (st[0]),
        .st1         (st[1]),
        .ss0         (ss[0]),
        .ss1         (ss[1]),
        .mode_noconc (mode_noconc),
        .mode_split  (mode_split),
        .resp        (resp)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arr_en      <= 1'b0;
            arr_we      <= 1'b0;
            arr_addr    <= '0;
            acc_bank    <= 1'b0;
            resp_status <= 1'b0;
            resp_err    <= 1'b0;
            op_err      <= 1'b0;
        end else begin
            arr_en      <= (resp == RSP_ARRAY);
            arr_we      <= (resp == RSP_ARRAY) && host_we;
            resp_status <= (resp == RSP_STATUS);
            resp_err    <= (resp == RSP_ERROR);
            op_err      <= reject;
            if (host_req) begin
                arr_addr <= host_addr;
                acc_bank <= dec_bank;
            end
        end
    end
endmodule

// File: rtl/dba_chk.sv
module dba_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_req,
    input logic       op_start,
    input logic [1:0] op_kind,
    input logic       susp_req,
    input logic       resume_req,
    input logic [1:0] bank_done,
    input logic       arr_en,
    input logic       resp_status,
    input logic       resp_err,
    input logic       op_err,
    input logic [1:0] bank_busy,
    input logic [1:0] bank_susp
);
    // R7
    err_no_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err |-> !arr_en && !resp_status);

    // R3
    resp_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_en || resp_status || resp_err) |-> $past(host_req));

    // R5
    op_err_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_err |-> $past(op_start));

    // R4
    busy0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_busy[0] && !bank_done[0] && !susp_req |=> bank_busy[0]);

    // R4
    busy1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_busy[1] && !bank_done[1] && !susp_req |=> bank_busy[1]);

    // R6
    susp0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_susp[0] && !resume_req |=> bank_susp[0]);

    // R6
    susp1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_susp[1] && !resume_req |=> bank_susp[1]);

    // R11
    chip_both_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_start && op_kind == 2'd2 && bank_busy == 2'b00 && bank_susp == 2'b00
        |=> bank_busy == 2'b11);
endmodule

bind dual_bank_arbiter dba_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_req    (host_req),
    .op_start    (op_start),
    .op_kind     (op_kind),
    .susp_req    (susp_req),
    .resume_req  (resume_req),
    .bank_done   (bank_done),
    .arr_en      (arr_en),
    .resp_status (resp_status),
    .resp_err    (resp_err),
    .op_err      (op_err),
    .bank_busy   (bank_busy),
    .bank_susp   (bank_susp)
);

// File: tb/dual_bank_arbiter_tb_top.sv
`timescale 1ns/1ps
module dual_bank_arbiter_tb_top;
    localparam int ADDR_W = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              part_opt = 1'b0, mode_noconc = 1'b0, mode_split = 1'b0;
    logic              host_req = 1'b0, host_we = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic              op_start = 1'b0;
    logic [1:0]        op_kind = 2'd0;
    logic              susp_req = 1'b0, resume_req = 1'b0;
    logic [1:0]        bank_done = 2'b00;
    logic              arr_en, arr_we, acc_bank, resp_status, resp_err, op_err;
    logic [ADDR_W-1:0] arr_addr;
    logic [1:0]        bank_busy, bank_susp;

    int checks = 0, failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dual_bank_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .part_opt(part_opt), .mode_noconc(mode_noconc),
        .mode_split(mode_split), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .op_start(op_start), .op_kind(op_kind),
        .susp_req(susp_req), .resume_req(resume_req), .bank_done(bank_done),
        .arr_en(arr_en), .arr_we(arr_we), .arr_addr(arr_addr), .acc_bank(acc_bank),
        .resp_status(resp_status), .resp_err(resp_err), .op_err(op_err),
        .bank_busy(bank_busy), .bank_susp(bank_susp)
    );

    // {part_opt, addr[19:18], expected bank}
    localparam logic [3:0] VEC [8] = '{
        4'b0000, 4'b0011, 4'b0101, 4'b0111,
        4'b1000, 4'b1010, 4'b1100, 4'b1111
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // resp code: 1 array, 2 status, 3 error, 0 none
    function automatic int rcode();
        return arr_en ? 1 : resp_status ? 2 : resp_err ? 3 : 0;
    endfunction

    task automatic access(input logic [ADDR_W-1:0] a, input logic we);
        host_addr = a; host_we = we; host_req = 1'b1;
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0;
    endtask

    task automatic op(input logic [1:0] k, input logic [ADDR_W-1:0] a);
        host_addr = a; op_kind = k; op_start = 1'b1;
        @(negedge clk);
        op_start = 1'b0;
    endtask

    task automatic done(input int b);
        bank_done[b] = 1'b1;
        @(negedge clk);
        bank_done = 2'b00;
    endtask

    task automatic suspend();
        susp_req = 1'b1; @(negedge clk); susp_req = 1'b0;
    endtask

    task automatic resume();
        resume_req = 1'b1; @(negedge clk); resume_req = 1'b0;
    endtask

    initial begin
        repeat (1000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12", "bank_busy", bank_busy, 0);
        chk("R12", "bank_susp", bank_susp, 0);
        chk("R12", "resp", rcode(), 0);
        chk("R12", "op_err", op_err, 0);

        // R1 / R2 decode table
        foreach (VEC[i]) begin
            part_opt = VEC[i][3];
            access({VEC[i][2:1], 18'h01234}, 1'b0);
            chk(VEC[i][3] ? "R2" : "R1", "acc_bank", acc_bank, VEC[i][0]);
            chk(VEC[i][3] ? "R2" : "R1", "resp", rcode(), 1);
            chk(VEC[i][3] ? "R2" : "R1", "arr_addr", arr_addr, {VEC[i][2:1], 18'h01234});
        end
        part_opt = 1'b0;

        // R3 / R4 / R5: program in bank 1
        op(2'd0, 20'h50000);
        chk("R4", "busy after prog", bank_busy, 2);
        chk("R5", "op_err admitted", op_err, 0);
        access(20'h10010, 1'b1);
        chk("R3", "idle bank array", rcode(), 1);
        chk("R3", "arr_we", arr_we, 1);
        chk("R3", "acc_bank", acc_bank, 0);
        access(20'h60000, 1'b0);
        chk("R4", "busy bank status", rcode(), 2);
        op(2'd1, 20'h40000);
        chk("R5", "op_err reject", op_err, 1);
        chk("R5", "busy kept", bank_busy, 2);
        @(negedge clk);
        chk("R5", "op_err one cycle", op_err, 0);
        op(2'd3, 20'h00000);
        chk("R5", "bad kind reject", op_err, 1);
        chk("R5", "bank0 untouched", bank_busy, 2);
        repeat (3) @(negedge clk);
        chk("R4", "busy held", bank_busy, 2);
        done(1);
        chk("R4", "busy released", bank_busy, 0);

        // R6 / R7 / R8: sector erase bank 0, sector 2
        op(2'd1, 20'h20000);
        chk("R6", "erase busy", bank_busy, 1);
        suspend();
        chk("R6", "susp busy", bank_busy, 0);
        chk("R6", "susp flag", bank_susp, 1);
        access(20'h20040, 1'b0);
        chk("R7", "suspended sector", rcode(), 3);
        access(20'h30000, 1'b0);
        chk("R7", "other sector", rcode(), 1);
        op(2'd0, 20'h20000);
        chk("R8", "prog susp sector", op_err, 1);
        chk("R8", "state kept", bank_susp, 1);
        op(2'd0, 20'h10000);
        chk("R8", "sprog err", op_err, 0);
        chk("R8", "sprog busy", bank_busy, 1);
        chk("R8", "sprog susp", bank_susp, 1);
        access(20'h00000, 1'b0);
        chk("R8", "sprog read", rcode(), 2);
        done(0);
        chk("R8", "back to susp busy", bank_busy, 0);
        chk("R8", "back to susp flag", bank_susp, 1);
        resume();
        chk("R6", "resume busy", bank_busy, 1);
        chk("R6", "resume susp", bank_susp, 0);
        done(0);
        chk("R6", "erase done", bank_busy, 0);

        // R9: no-concurrency mode
        mode_noconc = 1'b1;
        op(2'd0, 20'h50000);
        access(20'h00000, 1'b0);
        chk("R9", "idle bank status", rcode(), 2);
        done(1);
        access(20'h00000, 1'b0);
        chk("R9", "nothing busy array", rcode(), 1);
        mode_noconc = 1'b0;

        // R10: split mode
        mode_split = 1'b1;
        access(20'h00000, 1'b0);
        chk("R10", "opt0 small bank0", rcode(), 2);
        access(20'h80000, 1'b0);
        chk("R10", "opt0 big bank1", rcode(), 1);
        part_opt = 1'b1;
        access(20'h00000, 1'b0);
        chk("R10", "opt1 big bank0", rcode(), 1);
        access(20'hC0000, 1'b0);
        chk("R10", "opt1 small bank1", rcode(), 2);
        mode_split = 1'b0;
        part_opt = 1'b0;

        // R11: whole-array erase
        op(2'd2, 20'h00000);
        chk("R11", "both busy", bank_busy, 3);
        suspend();
        chk("R11", "no suspend", bank_busy, 3);
        chk("R11", "no susp flag", bank_susp, 0);
        op(2'd2, 20'h00000);
        chk("R11", "chip reject", op_err, 1);
        done(0);
        chk("R11", "bank0 released", bank_busy, 2);
        done(1);
        chk("R11", "all released", bank_busy, 0);
        op(2'd0, 20'h50000);
        op(2'd2, 20'h00000);
        chk("R11", "chip reject one busy", op_err, 1);
        chk("R11", "state kept", bank_busy, 2);
        done(1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule